// File: doc/BRIEF.md
# Self-Routing Banyan Switch Element with Input Queues

This block is one radix-c switching element of a clocked, self-routing multistage network in which every stage is built from identical elements and an N-port network uses log-base-c of N stages. Each input owns a small FIFO of fixed-size packets. A packet carries a routing tag. The element reads the one tag digit that belongs to its stage position and forwards the packet at the head of each queue to the output that digit names. Digits are taken from the most significant end of the tag. Stage 0 reads the top digit and each later stage reads the next one down.

Flow control is lossless. A packet that cannot move stays at the head of its queue. Each output has a valid/ready pair. `out_ready` means the next-stage queue has a free slot. `out_drain` means that queue is dequeuing in the same cycle. In local mode, a transfer on an output happens only when valid and ready are both high. In global mode, a transfer also happens when valid and drain are both high, so a packet may enter a full downstream queue that is freeing a slot. The input side follows the same rule. `in_ready` is high while the queue has room. In global mode a packet is also taken into a full queue when that queue pops in the same cycle, and `in_pop` reports that pop to the upstream element. `out_valid` never waits on `out_ready` or `out_drain`. When several queue heads want the same output, a round-robin arbiter for that output picks one of them.

Top module: `bsx_stage`

## Requirements
- R1: A head packet is presented on the output whose index equals its stage digit. The digit is the tag field of log2(RADIX) bits whose top bit is tag bit TAG_W-1-STAGE*log2(RADIX). With the default parameters, stage 0 routes on tag bit 2: a 0 selects output 0 and a 1 selects output 1.
- R2: Each input queue holds at most DEPTH (4) packets. `in_ready[i]` is high exactly while fewer than DEPTH packets are stored. In local mode, a packet offered to a full queue is not taken.
- R3: With `mode_global` low, an output transfers only in a cycle where `out_valid` and `out_ready` are both high. `out_drain` has no effect in this mode.
- R4: With `mode_global` high, an output also transfers when `out_valid` and `out_drain` are both high, even if `out_ready` is low. A full input queue that pops in that cycle accepts the offered packet, and its occupancy stays at DEPTH.
- R5: A blocked packet is never lost. While an output holds a packet it cannot send, `out_valid` stays high. Every accepted packet eventually leaves once the outputs accept.
- R6: Packets from one input that go to the same output leave in the order they were accepted.
- R7: Inputs contending for one output are served in round-robin order. With two inputs that stay backlogged, the source alternates on every transfer.
- R8: Forwarding is store-and-forward. A packet accepted into an empty queue first shows on an output in the cycle after it was accepted, never in the same cycle.
- R9: After reset, every queue is empty: `out_valid` is 0, `in_pop` is 0 and `in_ready` is all ones.
- R10: Heads bound for different outputs transfer in the same cycle. `in_pop[i]` is high in exactly the cycles where input i's head is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_global | input | 1 | 0: local backpressure, 1: global backpressure |
| in_valid | input | RADIX | Packet offered on input i |
| in_ready | output | RADIX | Input queue i has a free slot |
| in_pop | output | RADIX | Input queue i dequeues this cycle |
| in_tag | input | RADIX*TAG_W | Routing tag per input, input i at bits [i*TAG_W +: TAG_W] |
| in_data | input | RADIX*PAY_W | Payload per input, input i at bits [i*PAY_W +: PAY_W] |
| out_valid | output | RADIX | Packet presented on output o |
| out_ready | input | RADIX | Next-stage queue behind output o has space |
| out_drain | input | RADIX | Next-stage queue behind output o dequeues this cycle |
| out_tag | output | RADIX*TAG_W | Routing tag per output |
| out_data | output | RADIX*PAY_W | Payload per output |

## Verification
The properties assume that `in_valid` is not used to push data by itself: a packet counts as taken only in a cycle where the handshake rule for the current mode is met. They also assume that `out_drain` and `mode_global` describe a next-stage queue that really is dequeuing. The bench models both neighbours itself. It computes acceptance from the same rule and keeps a packet offered until that rule is met. It changes ready, drain and mode only on the falling edge. Under pseudo-random ready and drain patterns it treats a drain-only acceptance as a real transfer, so the behaviour of the neighbouring stages stays consistent with what the assertions assume.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
  typedef enum logic {BP_LOCAL = 1'b0, BP_GLOBAL = 1'b1} bp_mode_e;
endpackage

// File: rtl/bsx_fifo.sv
module bsx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign head     = slots[rd_q];
  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) slots[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bsx_rr_arb.sv
module bsx_rr_arb #(
  parameter int N = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               req,
  input  logic                       adv,
  output logic [N-1:0]               gnt,
  output logic [((N>1)?$clog2(N):1)-1:0] gnt_idx,
  output logic                       any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv && any)
      ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/bsx_stage.sv
module bsx_stage #(
  parameter int RADIX = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 3,
  parameter int PAY_W = 16,
  parameter int STAGE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_global,
  input  logic [RADIX-1:0]       in_valid,
  output logic [RADIX-1:0]       in_ready,
  output logic [RADIX-1:0]       in_pop,
  input  logic [RADIX*TAG_W-1:0] in_tag,
  input  logic [RADIX*PAY_W-1:0] in_data,
  output logic [RADIX-1:0]       out_valid,
  input  logic [RADIX-1:0]       out_ready,
  input  logic [RADIX-1:0]       out_drain,
  output logic [RADIX*TAG_W-1:0] out_tag,
  output logic [RADIX*PAY_W-1:0] out_data
);
  import bsx_pkg::*;

  localparam int DW  = $clog2(RADIX);
  localparam int PW  = TAG_W + PAY_W;
  localparam int MSB = TAG_W - 1 - STAGE * DW;
  localparam int IW  = (RADIX > 1) ? $clog2(RADIX) : 1;

  bp_mode_e bp_mode;
  assign bp_mode = bp_mode_e'(mode_global);

  logic [PW-1:0]    head     [RADIX];
  logic [RADIX-1:0] head_ok;
  logic [RADIX-1:0] q_full;
  logic [DW-1:0]    digit    [RADIX];
  logic [RADIX-1:0] push;
  logic [RADIX-1:0] req      [RADIX];
  logic [RADIX-1:0] gnt      [RADIX];
  logic [IW-1:0]    gidx     [RADIX];
  logic [RADIX-1:0] accept;
  logic [RADIX-1:0] fire;

  // input side: one queue per input
  for (genvar i = 0; i < RADIX; i++) begin : g_in
    assign in_ready[i] = !q_full[i];
    assign push[i] = in_valid[i] &&
                     (!q_full[i] || (bp_mode == BP_GLOBAL && in_pop[i]));
    assign digit[i] = head[i][PAY_W + MSB -: DW];

    bsx_fifo #(.DEPTH(DEPTH), .W(PW)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push[i]),
      .wdata    ({in_tag[i*TAG_W +: TAG_W], in_data[i*PAY_W +: PAY_W]}),
      .pop      (in_pop[i]),
      .head     (head[i]),
      .nonempty (head_ok[i]),
      .full     (q_full[i])
    );
  end

  // output side: one arbiter per output
  for (genvar o = 0; o < RADIX; o++) begin : g_out
    for (genvar i = 0; i < RADIX; i++) begin : g_req
      assign req[o][i] = head_ok[i] && (digit[i] == DW'(o));
    end

    bsx_rr_arb #(.N(RADIX)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[o]),
      .adv     (fire[o]),
      .gnt     (gnt[o]),
      .gnt_idx (gidx[o]),
      .any     (out_valid[o])
    );

    assign accept[o] = out_ready[o] || (bp_mode == BP_GLOBAL && out_drain[o]);
    assign fire[o]   = out_valid[o] && accept[o];
    assign out_tag [o*TAG_W +: TAG_W] = head[gidx[o]][PW-1 -: TAG_W];
    assign out_data[o*PAY_W +: PAY_W] = head[gidx[o]][PAY_W-1:0];
  end

  always_comb begin
    in_pop = '0;
    for (int o = 0; o < RADIX; o++)
      for (int i = 0; i < RADIX; i++)
        if (fire[o] && gnt[o][i]) in_pop[i] = 1'b1;
  end
endmodule

// File: rtl/bsx_stage_chk.sv
module bsx_stage_chk #(
  parameter int RADIX = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 3,
  parameter int PAY_W = 16,
  parameter int STAGE = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_global,
  input logic [RADIX-1:0]       in_valid,
  input logic [RADIX-1:0]       in_ready,
  input logic [RADIX-1:0]       in_pop,
  input logic [RADIX-1:0]       out_valid,
  input logic [RADIX-1:0]       out_ready,
  input logic [RADIX-1:0]       out_drain,
  input logic [RADIX*TAG_W-1:0] out_tag
);
  localparam int DW  = $clog2(RADIX);
  localparam int MSB = TAG_W - 1 - STAGE * DW;
  localparam int CW  = $clog2(DEPTH + 2);

  logic [CW-1:0] occ [RADIX];

  for (genvar i = 0; i < RADIX; i++) begin : g_i
    logic took;
    assign took = in_valid[i] && (in_ready[i] || (mode_global && in_pop[i]));
    always_ff @(posedge clk) begin
      if (!rst_n) occ[i] <= '0;
      else occ[i] <= occ[i] + CW'(took) - CW'(in_pop[i]);
    end

    p_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[i] <= CW'(DEPTH)) && (in_ready[i] == (occ[i] != CW'(DEPTH))));
    p_sf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[i] == '0) |-> !in_pop[i]);
  end

  for (genvar o = 0; o < RADIX; o++) begin : g_o
    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> (out_tag[o*TAG_W + MSB -: DW] == DW'(o)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o] && !(mode_global && out_drain[o])) |=> out_valid[o]);
  end

  p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_global |-> ($countones(in_pop) == $countones(out_valid & out_ready)));
  p_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_global |-> ($countones(in_pop) == $countones(out_valid & (out_ready | out_drain))));
endmodule

bind bsx_stage bsx_stage_chk #(
  .RADIX(RADIX), .DEPTH(DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W), .STAGE(STAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_global(mode_global),
  .in_valid(in_valid), .in_ready(in_ready), .in_pop(in_pop),
  .out_valid(out_valid), .out_ready(out_ready), .out_drain(out_drain),
  .out_tag(out_tag)
);

// File: tb/sim_bsx_stage.sv
`timescale 1ns/1ps
module sim_bsx_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_global = 1'b0;
  logic [1:0]  in_valid = '0;
  logic [1:0]  in_ready, in_pop, out_valid;
  logic [5:0]  in_tag = '0;
  logic [31:0] in_data = '0;
  logic [1:0]  out_ready = '0, out_drain = '0;
  logic [5:0]  out_tag;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  bsx_stage u0 (
    .clk(clk), .rst_n(rst_n), .mode_global(mode_global),
    .in_valid(in_valid), .in_ready(in_ready), .in_pop(in_pop),
    .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_drain(out_drain),
    .out_tag(out_tag), .out_data(out_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [18:0] exp_q [2][2][$];
  int src_log[$];
  int seq = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // offer one packet on input i; caller is at a falling edge
  task automatic push(int i, logic [2:0] tag);
    logic [15:0] d;
    d = {4'(i), 12'(seq)};
    seq++;
    in_tag[i*3 +: 3]   = tag;
    in_data[i*16 +: 16] = d;
    in_valid[i] = 1'b1;
    forever begin
      #1;
      if (in_ready[i] || (mode_global && in_pop[i])) break;
      @(negedge clk);
    end
    exp_q[tag[2]][i].push_back({tag, d});
    @(negedge clk);
    in_valid[i] = 1'b0;
  endtask

  function automatic int pending();
    int s = 0;
    for (int o = 0; o < 2; o++)
      for (int i = 0; i < 2; i++) s += exp_q[o][i].size();
    return s;
  endfunction

  task automatic drain_all();
    out_ready = 2'b11; out_drain = '0; mode_global = 1'b0;
    for (int k = 0; k < 60 && pending() != 0; k++) @(negedge clk);
    #1 chk(pending() == 0, "R5", "packets left after drain", pending(), 0);
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        for (int o = 0; o < 2; o++) begin
          if (out_valid[o] && (out_ready[o] || (mode_global && out_drain[o]))) begin
            logic [18:0] got;
            int src;
            got = {out_tag[o*3 +: 3], out_data[o*16 +: 16]};
            src = int'(got[15:12]);
            if (o == 0) src_log.push_back(src);
            if (src > 1 || exp_q[o][src].size() == 0) begin
              chk(0, "R1", "unexpected packet on output", int'(got), o);
            end else begin
              logic [18:0] want;
              want = exp_q[o][src].pop_front();
              chk(got == want, "R6", "packet order/content", int'(got), int'(want));
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R5", "watchdog expired", 0, 1);
    wrap_up();
  end

  bit rnd_on = 0;
  initial begin
    logic [15:0] lf = 16'hACE1;
    forever begin
      @(negedge clk);
      if (rnd_on) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        out_ready   = lf[1:0];
        out_drain   = lf[4:3];
        mode_global = lf[7];
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 2'b00, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 2'b11, "R9", "in_ready after reset", int'(in_ready), 3);
    chk(in_pop == 2'b00, "R9", "in_pop after reset", int'(in_pop), 0);
    @(negedge clk);

    // R2 / R5: fill input 0 with outputs blocked
    out_ready = '0; out_drain = '0; mode_global = 1'b0;
    for (int k = 0; k < 4; k++) push(0, 3'(k));
    #1;
    chk(in_ready[0] == 1'b0, "R2", "in_ready with full queue", int'(in_ready[0]), 0);
    chk(out_valid[0] == 1'b1, "R5", "blocked head visible", int'(out_valid[0]), 1);
    in_tag[2:0] = 3'b000; in_data[15:0] = 16'h0FFF; in_valid[0] = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(in_pop[0] == 1'b0 && in_ready[0] == 1'b0, "R2", "fifth packet not taken",
        int'({in_pop[0], in_ready[0]}), 0);
    chk(out_valid == 2'b01, "R5", "head held while blocked", int'(out_valid), 1);
    in_valid[0] = 1'b0;

    // R3: drain ignored in local mode
    @(negedge clk);
    out_drain[0] = 1'b1;
    #1 chk(in_pop[0] == 1'b0, "R3", "drain ignored in local mode", int'(in_pop[0]), 0);

    // R4: global mode sends on drain and refills the full queue
    @(negedge clk);
    mode_global = 1'b1;
    in_tag[2:0] = 3'b011; in_data[15:0] = {4'd0, 12'(seq)}; in_valid[0] = 1'b1;
    #1;
    chk(in_pop[0] == 1'b1, "R4", "transfer on drain in global mode", int'(in_pop[0]), 1);
    chk(in_ready[0] == 1'b0, "R4", "queue still reported full", int'(in_ready[0]), 0);
    exp_q[0][0].push_back({3'b011, 4'd0, 12'(seq)});
    seq++;
    @(negedge clk);
    in_valid[0] = 1'b0; out_drain = '0; mode_global = 1'b0;
    #1 chk(in_ready[0] == 1'b0, "R4", "occupancy stays at depth", int'(in_ready[0]), 0);
    @(negedge clk);
    drain_all();

    // R7: two backlogged inputs on output 0
    out_ready = '0;
    fork
      begin push(0, 3'b000); push(0, 3'b010); end
      begin push(1, 3'b001); push(1, 3'b011); end
    join
    src_log.delete();
    out_ready = 2'b01;
    repeat (6) @(negedge clk);
    chk(src_log.size() == 4, "R7", "transfers on output 0", src_log.size(), 4);
    if (src_log.size() == 4)
      for (int k = 0; k < 3; k++)
        chk(src_log[k] != src_log[k+1], "R7", "source alternation", src_log[k+1], 1 - src_log[k]);
    drain_all();

    // R8: store-and-forward latency
    in_tag[5:3] = 3'b100; in_data[31:16] = {4'd1, 12'(seq)}; in_valid[1] = 1'b1;
    #1;
    chk(in_ready[1] == 1'b1, "R8", "empty queue accepts", int'(in_ready[1]), 1);
    chk(out_valid[1] == 1'b0, "R8", "no output in accept cycle", int'(out_valid[1]), 0);
    exp_q[1][1].push_back({3'b100, 4'd1, 12'(seq)});
    seq++;
    @(negedge clk);
    in_valid[1] = 1'b0;
    #1 chk(out_valid[1] == 1'b1, "R8", "output one cycle later", int'(out_valid[1]), 1);
    @(negedge clk);
    drain_all();

    // R10 / R1: crossing traffic moves in parallel
    out_ready = '0;
    fork
      push(0, 3'b110);
      push(1, 3'b001);
    join
    out_ready = 2'b11;
    #1;
    chk(out_valid == 2'b11, "R10", "both outputs valid", int'(out_valid), 3);
    chk(in_pop == 2'b11, "R10", "both inputs pop", int'(in_pop), 3);
    chk(out_data[31:28] == 4'd0 && out_data[15:12] == 4'd1, "R1", "crossed sources",
        int'({out_data[31:28], out_data[15:12]}), 1);
    @(negedge clk);
    drain_all();

    // mixed traffic with random ready, drain and mode
    rnd_on = 1;
    fork
      for (int k = 0; k < 30; k++) push(0, 3'((k * 5) ^ (k >> 1)));
      for (int k = 0; k < 30; k++) push(1, 3'((k * 3 + 1) ^ (k >> 2)));
    join
    rnd_on = 0;
    @(negedge clk);
    drain_all();

    wrap_up();
  end
endmodule